// File: doc/BRIEF.md
# Dual-Port Token Semaphore Bank

This block holds a small set of ownership tokens that two independent ports share. Software on each side uses the tokens to agree on who may currently work in a given region of a shared memory. The tokens sit apart from that memory: the unit never looks at memory addresses and never stalls an access. Which region a token stands for is purely a matter of software convention.

Each port has one access channel: a select, a write strobe, a token index, a one-bit write value and a one-bit read value. A port asks for a token by writing 0 to it and gives it up by writing 1. It learns whether it holds the token by reading it back. A request made while the other side holds the token stays latched. The token moves to the waiting side in the same clock edge at which the holder gives it up. When both ports ask for the same free token in the same cycle, a fixed rule picks one winner. By default that winner is the left port. Both ports follow exactly the same protocol.

Top module: `sema_bank`

## Requirements
- R1: After reset every token is free, and reading any token returns 1 on both ports.
- R2: A write of value 0 (select=1, write=1) to a free token gives that port ownership at the next clock edge. From then on, reading that token returns 0 to the owner and 1 to the other port.
- R3: When both ports write 0 to the same free token in the same cycle, the left port becomes the owner. The right port's request stays latched as pending.
- R4: A write of 0 to a token held by the other side does not change ownership. The request is kept, and the token passes to the requester at the edge where the holder writes 1 to it.
- R5: A write of 1 by the owner frees the token when no request from the other side is pending. Both ports then read 1.
- R6: A write of 1 by a port that does not own a token withdraws that port's pending request and leaves the owner unchanged. A later release by the owner then leaves the token free.
- R7: An operation on one token leaves the ownership and pending state of every other token unchanged.
- R8: The right port uses exactly the same protocol as the left port. It can claim, hold, read and release any token alone.
- R9: Cycles with select=0, or with select=1 and write=0, change no ownership. A write of 0 by the current owner to its own token also changes nothing.
- R10: No token is ever owned by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_sel | input | 1 | Left port access select |
| lft_wr | input | 1 | Left port write strobe (valid with select) |
| lft_idx | input | IDX_W (3) | Left port token index |
| lft_wdata | input | 1 | Left port write value: 0 request, 1 release |
| lft_rdata | output | 1 | Left port readback of token at lft_idx: 0 if held by left |
| rgt_sel | input | 1 | Right port access select |
| rgt_wr | input | 1 | Right port write strobe (valid with select) |
| rgt_idx | input | IDX_W (3) | Right port token index |
| rgt_wdata | input | 1 | Right port write value: 0 request, 1 release |
| rgt_rdata | output | 1 | Right port readback of token at rgt_idx: 0 if held by right |

## Verification
The bench targets same-cycle requests for a free token. A design that grants both sides there, or grants the right side, would show two owners or the wrong winner. It drives handover of a held token to a waiting requester. A design that forgot the pending request would leave the token free, and one that granted too early would take it from the holder. It covers withdrawal of a pending request before the release. A design that ignored the withdrawal would wrongly hand the token over. It also checks that reads and unselected writes leave every token alone. Randomised traffic is limited to a few indices so that collisions are frequent, and all tokens are compared on both ports after every cycle. This catches cross-token disturbance.

// File: rtl/sema_pkg.sv
package sema_pkg;

   // Ownership of one token; the 2'b11 code is never legal
   typedef enum logic [1:0] {
      OWN_NONE  = 2'b00,
      OWN_LEFT  = 2'b01,
      OWN_RIGHT = 2'b10
   } own_e;

   // Decoded per-token command from one port
   typedef struct packed {
      logic claim;
      logic drop;
   } tok_cmd_t;

endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
   parameter int NUM_TOKENS = 8,
   localparam int IDX_W = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
   input  logic                     sel,
   input  logic                     wr,
   input  logic [IDX_W-1:0]         idx,
   input  logic                     wdata,
   output sema_pkg::tok_cmd_t [NUM_TOKENS-1:0] cmd
);

   logic wr_hit;

   assign wr_hit = sel & wr;

   always_comb begin
      for (int t = 0; t < NUM_TOKENS; t++) begin
         cmd[t].claim = wr_hit && !wdata && (idx == IDX_W'(t));
         cmd[t].drop  = wr_hit &&  wdata && (idx == IDX_W'(t));
      end
   end

endmodule

// File: rtl/sema_cell.sv
module sema_cell #(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sema_pkg::tok_cmd_t l_cmd,
   input  sema_pkg::tok_cmd_t r_cmd,
   output logic               own_l,
   output logic               own_r,
   output logic               pend_l,
   output logic               pend_r
);
   import sema_pkg::*;

   own_e state_q, state_d;
   logic lreq_q, rreq_q;
   logic lreq_d, rreq_d;
   logic pick_l, pick_r;

   // Request latches: a claim sets, a drop clears
   always_comb begin
      lreq_d = lreq_q;
      if (l_cmd.claim)     lreq_d = 1'b1;
      else if (l_cmd.drop) lreq_d = 1'b0;
      rreq_d = rreq_q;
      if (r_cmd.claim)     rreq_d = 1'b1;
      else if (r_cmd.drop) rreq_d = 1'b0;
   end

   // Fixed tie rule chosen at elaboration
   generate
      if (LEFT_WINS) begin : g_tie_left
         assign pick_l = lreq_d;
         assign pick_r = rreq_d & ~lreq_d;
      end else begin : g_tie_right
         assign pick_r = rreq_d;
         assign pick_l = lreq_d & ~rreq_d;
      end
   endgenerate

   always_comb begin
      state_d = OWN_NONE;
      if (state_q == OWN_LEFT && lreq_d)       state_d = OWN_LEFT;
      else if (state_q == OWN_RIGHT && rreq_d) state_d = OWN_RIGHT;
      else if (pick_l)                         state_d = OWN_LEFT;
      else if (pick_r)                         state_d = OWN_RIGHT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OWN_NONE;
         lreq_q  <= 1'b0;
         rreq_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         lreq_q  <= lreq_d;
         rreq_q  <= rreq_d;
      end
   end

   assign own_l  = (state_q == OWN_LEFT);
   assign own_r  = (state_q == OWN_RIGHT);
   assign pend_l = lreq_q & ~own_l;
   assign pend_r = rreq_q & ~own_r;

endmodule

// File: rtl/sema_rd_mux.sv
module sema_rd_mux #(
   parameter int NUM_TOKENS = 8,
   localparam int IDX_W = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
   input  logic [IDX_W-1:0]      idx,
   input  logic [NUM_TOKENS-1:0] own,
   output logic                  rdata
);

   // Held-by-this-port reads 0; free, other-held or unmapped read 1
   always_comb begin
      rdata = 1'b1;
      for (int t = 0; t < NUM_TOKENS; t++) begin
         if (idx == IDX_W'(t)) rdata = ~own[t];
      end
   end

endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
   parameter int NUM_TOKENS = 8,
   parameter bit LEFT_WINS  = 1'b1,
   localparam int IDX_W = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lft_sel,
   input  logic             lft_wr,
   input  logic [IDX_W-1:0] lft_idx,
   input  logic             lft_wdata,
   output logic             lft_rdata,
   input  logic             rgt_sel,
   input  logic             rgt_wr,
   input  logic [IDX_W-1:0] rgt_idx,
   input  logic             rgt_wdata,
   output logic             rgt_rdata
);
   import sema_pkg::*;

   generate
      if (NUM_TOKENS < 2 || NUM_TOKENS > 64) begin : g_bad_count
         $fatal(1, "sema_bank: NUM_TOKENS must lie in 2..64");
      end
   endgenerate

   tok_cmd_t [NUM_TOKENS-1:0] l_cmd, r_cmd;
   logic [NUM_TOKENS-1:0] own_l, own_r, pend_l, pend_r;

   sema_port_dec #(.NUM_TOKENS(NUM_TOKENS)) u_dec_l (
      .sel(lft_sel), .wr(lft_wr), .idx(lft_idx), .wdata(lft_wdata), .cmd(l_cmd)
   );

   sema_port_dec #(.NUM_TOKENS(NUM_TOKENS)) u_dec_r (
      .sel(rgt_sel), .wr(rgt_wr), .idx(rgt_idx), .wdata(rgt_wdata), .cmd(r_cmd)
   );

   generate
      for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_tok
         sema_cell #(.LEFT_WINS(LEFT_WINS)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_cmd  (l_cmd[g]),
            .r_cmd  (r_cmd[g]),
            .own_l  (own_l[g]),
            .own_r  (own_r[g]),
            .pend_l (pend_l[g]),
            .pend_r (pend_r[g])
         );
      end
   endgenerate

   sema_rd_mux #(.NUM_TOKENS(NUM_TOKENS)) u_rd_l (
      .idx(lft_idx), .own(own_l), .rdata(lft_rdata)
   );

   sema_rd_mux #(.NUM_TOKENS(NUM_TOKENS)) u_rd_r (
      .idx(rgt_idx), .own(own_r), .rdata(rgt_rdata)
   );

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
   parameter int NUM_TOKENS = 8,
   parameter bit LEFT_WINS  = 1'b1,
   localparam int IDX_W = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  lft_sel,
   input logic                  lft_wr,
   input logic [IDX_W-1:0]      lft_idx,
   input logic                  lft_wdata,
   input logic                  lft_rdata,
   input logic                  rgt_sel,
   input logic                  rgt_wr,
   input logic [IDX_W-1:0]      rgt_idx,
   input logic                  rgt_wdata,
   input logic                  rgt_rdata,
   input logic [NUM_TOKENS-1:0] own_l,
   input logic [NUM_TOKENS-1:0] own_r,
   input logic [NUM_TOKENS-1:0] pend_l,
   input logic [NUM_TOKENS-1:0] pend_r
);

   logic l_wr_any, r_wr_any;
   assign l_wr_any = lft_sel & lft_wr;
   assign r_wr_any = rgt_sel & rgt_wr;

   AST_RESET_FREE: assert property (@(posedge clk)
      $rose(rst_n) |-> (own_l == '0) && (own_r == '0)); // R1

   AST_READ_OWNED_L: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lft_idx) < NUM_TOKENS) && own_l[lft_idx] |-> !lft_rdata); // R2

   AST_READ_OWNED_R: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rgt_idx) < NUM_TOKENS) && own_r[rgt_idx] |-> !rgt_rdata); // R8

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !l_wr_any && !r_wr_any |=> $stable(own_l) && $stable(own_r)); // R9

   generate
      for (genvar t = 0; t < NUM_TOKENS; t++) begin : g_t
         logic lc, ld, rc, rd;
         assign lc = l_wr_any && !lft_wdata && (lft_idx == IDX_W'(t));
         assign ld = l_wr_any &&  lft_wdata && (lft_idx == IDX_W'(t));
         assign rc = r_wr_any && !rgt_wdata && (rgt_idx == IDX_W'(t));
         assign rd = r_wr_any &&  rgt_wdata && (rgt_idx == IDX_W'(t));

         AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            !(own_l[t] && own_r[t])); // R10

         if (LEFT_WINS) begin : g_tie
            AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
               lc && rc && !own_l[t] && !own_r[t] |=> own_l[t] && pend_r[t]); // R3
         end

         AST_HANDOVER_R: assert property (@(posedge clk) disable iff (!rst_n)
            own_l[t] && pend_r[t] && ld && !rd |=> own_r[t]); // R4

         AST_FREE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            own_l[t] && ld && !pend_r[t] && !rc |=> !own_l[t] && !own_r[t]); // R5

         AST_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
            own_l[t] && !ld |=> own_l[t]); // R6

         AST_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
            own_r[t] && !rd |=> own_r[t]); // R7
      end
   endgenerate

endmodule

bind sema_bank sema_bank_chk #(.NUM_TOKENS(NUM_TOKENS), .LEFT_WINS(LEFT_WINS)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lft_sel(lft_sel), .lft_wr(lft_wr), .lft_idx(lft_idx),
   .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
   .rgt_sel(rgt_sel), .rgt_wr(rgt_wr), .rgt_idx(rgt_idx),
   .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata),
   .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sema_bank_tb.sv
`timescale 1ns/100ps
module sema_bank_tb;
   localparam int N  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lft_sel = 0, lft_wr = 0, lft_wdata = 0;
   logic rgt_sel = 0, rgt_wr = 0, rgt_wdata = 0;
   logic [IW-1:0] lft_idx = '0, rgt_idx = '0;
   logic lft_rdata, rgt_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Reference state: owner per token and latched requests
   bit m_ol[N];
   bit m_or[N];
   bit m_ql[N];
   bit m_qr[N];

   always #10 clk = ~clk;

   sema_bank #(.NUM_TOKENS(N)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .lft_sel(lft_sel), .lft_wr(lft_wr), .lft_idx(lft_idx),
      .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
      .rgt_sel(rgt_sel), .rgt_wr(rgt_wr), .rgt_idx(rgt_idx),
      .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata)
   );

   function automatic void model_step(bit ls, bit lw, int li, bit ld,
                                      bit rs, bit rw, int ri, bit rd);
      for (int t = 0; t < N; t++) begin
         if (ls && lw && li == t) m_ql[t] = !ld;
         if (rs && rw && ri == t) m_qr[t] = !rd;
         // holder keeps while its request stands; else left first, then right
         if (m_ol[t] && m_ql[t]) begin
         end else if (m_or[t] && m_qr[t]) begin
         end else begin
            m_ol[t] = m_ql[t];
            m_or[t] = !m_ql[t] && m_qr[t];
         end
      end
   endfunction

   function automatic bit exp_read(bit left_side, int t);
      return left_side ? !m_ol[t] : !m_or[t];
   endfunction

   task automatic check_bit(string rq, string what, int t, bit got, bit exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s token %0d: got %0b expected %0b", rq, what, t, got, exp);
      end
   endtask

   // Read back all tokens on both ports with select low
   task automatic verify_all(string rq);
      lft_sel = 0; rgt_sel = 0; lft_wr = 0; rgt_wr = 0;
      for (int t = 0; t < N; t++) begin
         lft_idx = IW'(t); rgt_idx = IW'(t);
         #1;
         check_bit(rq, "left read", t, lft_rdata, exp_read(1'b1, t));
         check_bit(rq, "right read", t, rgt_rdata, exp_read(1'b0, t));
      end
   endtask

   task automatic cyc(bit ls, bit lw, int li, bit ld,
                      bit rs, bit rw, int ri, bit rd, string rq);
      @(negedge clk);
      lft_sel = ls; lft_wr = lw; lft_idx = IW'(li); lft_wdata = ld;
      rgt_sel = rs; rgt_wr = rw; rgt_idx = IW'(ri); rgt_wdata = rd;
      @(posedge clk);
      model_step(ls, lw, li, ld, rs, rw, ri, rd);
      #1;
      verify_all(rq);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      for (int t = 0; t < N; t++) begin
         m_ol[t] = 0; m_or[t] = 0; m_ql[t] = 0; m_qr[t] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      verify_all("R1");

      // R2: left claims a free token
      cyc(1,1,2,0, 0,0,0,0, "R2");
      // R8: right claims alone
      cyc(0,0,0,0, 1,1,5,0, "R8");
      // R3: same-cycle claim of a free token, left wins
      cyc(1,1,6,0, 1,1,6,0, "R3");
      // R4: right asks for token 2 held by left; no change yet
      cyc(0,0,0,0, 1,1,2,0, "R4");
      // R9: owner re-claim and reads change nothing
      cyc(1,1,2,0, 1,0,2,0, "R9");
      cyc(1,0,2,1, 0,1,5,1, "R9");
      // R4: left releases, right takes over
      cyc(1,1,2,1, 0,0,0,0, "R4");
      // R5: right releases with no waiter
      cyc(0,0,0,0, 1,1,2,1, "R5");
      // R6: right withdraws pending request on token 6, then left releases
      cyc(0,0,0,0, 1,1,6,1, "R6");
      cyc(1,1,6,1, 0,0,0,0, "R6");
      // R6: non-owner release leaves owner of token 5
      cyc(1,1,5,1, 0,0,0,0, "R6");
      // R8: right releases token 5
      cyc(0,0,0,0, 1,1,5,1, "R8");
      // R7: random traffic focused on a few tokens
      for (int i = 0; i < 3000; i++) begin
         int span;
         span = (i % 4 == 0) ? N : 3;
         cyc($urandom_range(1,0) == 1, $urandom_range(3,0) != 0,
             int'($urandom_range(span-1,0)), $urandom_range(1,0) == 1,
             $urandom_range(1,0) == 1, $urandom_range(3,0) != 0,
             int'($urandom_range(span-1,0)), $urandom_range(1,0) == 1, "R7");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule